// File: doc/BRIEF.md
# Reversible Adder Network (Ripple and Carry-Save)

This block is a bit-level model, on classical basis states, of an adder assembled only from reversible cells. Two cell types are used. The four-line full-adder cell keeps two operand lines as they are, overwrites a third line with the parity of the three, and toggles a fourth, ancilla, line by the three-input majority. The majority cell does only the toggle and keeps all three operand lines. Each cell maps its 16 line states one-to-one. A 3-in/2-out adder cannot be made one-to-one with a single extra output: three input patterns give sum 1 with carry 0, and three give sum 0 with carry 1. That is why each cell carries four lines.

A one-bit mode input chooses between two networks over the same line set: operand lines A, B, C and ancilla lines K, each `WIDTH` bits. In ripple mode, full-adder cells run upward from bit 0. Bit 0 takes its carry from C[0], and each bit's carry lands in that bit's ancilla. A reverse chain of majority cells, run from bit WIDTH-2 down to 0, then clears every lower carry and leaves the sum on the B lines and the carry-out on the top ancilla. In carry-save mode, every bit gets one full-adder cell. The sum stays on line C[i] and the majority lands on ancilla K[i], which carries weight 2^(i+1).

A parameter selects whether the outputs are registered. The registered variant adds one clock of latency.

Top module: `rev_add_net`

## Requirements
- R1: The full-adder cell, on lines (A,B,C,D), outputs A and B unchanged, A^B^C on the C position, and D^maj(A,B,C) on the D position.
- R2: The majority cell outputs A, B and C unchanged and D^maj(A,B,C) on the D position.
- R3: Each cell maps the 16 states of its four lines one-to-one, so its 16 outputs form a permutation of 0..15.
- R4: With mode = 0 (ripple), out_b equals (in_a + in_b + in_c[0]) mod 2^WIDTH, and out_anc[WIDTH-1] is the carry out of that sum.
- R5: With mode = 0 and in_anc all zero, out_anc[WIDTH-2:0] is all zero, so every intermediate carry is cleared.
- R6: With mode = 0, out_a equals in_a and out_c equals in_c. C[0] serves as the carry-in line, and the upper C lines are ignored.
- R7: With mode = 1 (carry-save), out_a = in_a, out_b = in_b, out_c[i] = a^b^c at bit i, and out_anc[i] = maj(a,b,c) at bit i, so out_c + 2*out_anc = in_a + in_b + in_c.
- R8: The ancilla input in_anc must be zero on entry in both modes. A nonzero ancilla is flagged.
- R9: With REG_OUT = 1, outputs follow the inputs one clock later and hold their old value until that edge. While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| mode | input | 1 | 0 = ripple add, 1 = 3->2 carry-save |
| in_a | input | WIDTH | Operand line set A |
| in_b | input | WIDTH | Operand line set B |
| in_c | input | WIDTH | Third operand (carry-save) or carry-in on bit 0 (ripple) |
| in_anc | input | WIDTH | Ancilla lines, zero on entry |
| out_a | output | WIDTH | A lines after the network |
| out_b | output | WIDTH | B lines (sum in ripple mode) |
| out_c | output | WIDTH | C lines (per-bit sum in carry-save mode) |
| out_anc | output | WIDTH | Ancilla lines (carry-out on top in ripple, shifted carries in carry-save) |

## Verification
A wrong cell or a miswired line shows up in the same sample as the operands that expose it. With registered outputs, that is one clock after those operands are applied. The symptom is a wrong sum, a pass-through line that has changed, or a leftover 1 on a lower ancilla in ripple mode. A faulty uncompute step leaves its trace only on the ancilla outputs, never on the sum. A sweep over every operand triple in both modes therefore reaches each carry path and each clearing step. Exhaustive truth tables of the two cells catch any loss of reversibility before the network is involved.

// File: rtl/rva_pkg.sv
package rva_pkg;

   typedef enum logic {
      MODE_RIPPLE = 1'b0,
      MODE_CSA    = 1'b1
   } rva_mode_e;

   function automatic logic maj3(input logic x, input logic y, input logic z);
      return (x & y) | (x & z) | (y & z);
   endfunction

endpackage

// File: rtl/rva_fa_cell.sv
// Reversible four-line full-adder cell: two lines kept, parity on the
// third, majority folded into the fourth.
module rva_fa_cell
   import rva_pkg::*;
(
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   input  logic d_i,
   output logic a_o,
   output logic b_o,
   output logic s_o,
   output logic k_o
);
   assign a_o = a_i;
   assign b_o = b_i;
   assign s_o = a_i ^ b_i ^ c_i;
   assign k_o = d_i ^ maj3(a_i, b_i, c_i);
endmodule

// File: rtl/rva_maj_cell.sv
// Reversible majority cell: three lines kept, majority folded into the fourth.
module rva_maj_cell
   import rva_pkg::*;
(
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   input  logic d_i,
   output logic a_o,
   output logic b_o,
   output logic c_o,
   output logic k_o
);
   assign a_o = a_i;
   assign b_o = b_i;
   assign c_o = c_i;
   assign k_o = d_i ^ maj3(a_i, b_i, c_i);
endmodule

// File: rtl/rva_ripple.sv
// Forward chain of full-adder cells, then a downward chain of majority
// cells that clears the carries below the top bit. Each line is threaded
// from cell to cell, so the network stays a composition of bijections.
module rva_ripple #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   input  logic [WIDTH-1:0] anc_i,
   output logic [WIDTH-1:0] a_o,
   output logic [WIDTH-1:0] sum_o,
   output logic             cin_o,
   output logic [WIDTH-1:0] anc_o
);
   localparam int TOP = WIDTH - 1;

   logic [WIDTH-1:0] cy_in;
   logic [WIDTH-1:0] fw_a;
   logic [WIDTH-1:0] fw_cy;
   logic [WIDTH-1:0] fw_s;
   logic [WIDTH-1:0] fw_k;

   logic [TOP-1:0]   rv_d;
   logic [TOP-1:0]   rv_a;
   logic [TOP-1:0]   rv_cy;
   logic [TOP-1:0]   rv_ns;
   logic [TOP-1:0]   rv_k;

   // Forward pass: the carry line of bit i is the K output of bit i-1.
   for (genvar i = 0; i < WIDTH; i++) begin : g_fwd
      if (i == 0) begin : g_first
         assign cy_in[i] = cin_i;
      end else begin : g_next
         assign cy_in[i] = fw_k[i-1];
      end
      // Sum lands on the B position (cell C input); carry line passes.
      rva_fa_cell u_fa (
         .a_i (a_i[i]),
         .b_i (cy_in[i]),
         .c_i (b_i[i]),
         .d_i (anc_i[i]),
         .a_o (fw_a[i]),
         .b_o (fw_cy[i]),
         .s_o (fw_s[i]),
         .k_o (fw_k[i])
      );
   end

   // Reverse pass, bit TOP-1 down to 0. With sum s = a^b^c, the original
   // majority equals maj(a, c, ~s), so the sum line is inverted around the
   // cell and restored afterwards.
   for (genvar i = 0; i < TOP; i++) begin : g_rev
      if (i == TOP - 1) begin : g_hi
         assign rv_d[i] = fw_cy[TOP];
      end else begin : g_lo
         assign rv_d[i] = rv_cy[i+1];
      end
      rva_maj_cell u_mj (
         .a_i (fw_a[i]),
         .b_i (fw_cy[i]),
         .c_i (~fw_s[i]),
         .d_i (rv_d[i]),
         .a_o (rv_a[i]),
         .b_o (rv_cy[i]),
         .c_o (rv_ns[i]),
         .k_o (rv_k[i])
      );
      assign a_o[i]   = rv_a[i];
      assign sum_o[i] = ~rv_ns[i];
      assign anc_o[i] = rv_k[i];
   end

   assign a_o[TOP]   = fw_a[TOP];
   assign sum_o[TOP] = fw_s[TOP];
   assign anc_o[TOP] = fw_k[TOP];
   assign cin_o      = rv_cy[0];
endmodule

// File: rtl/rva_csa.sv
// One full-adder cell per bit; K of bit i carries weight 2^(i+1).
module rva_csa #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [WIDTH-1:0] c_i,
   input  logic [WIDTH-1:0] anc_i,
   output logic [WIDTH-1:0] a_o,
   output logic [WIDTH-1:0] b_o,
   output logic [WIDTH-1:0] s_o,
   output logic [WIDTH-1:0] k_o
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      rva_fa_cell u_fa (
         .a_i (a_i[i]),
         .b_i (b_i[i]),
         .c_i (c_i[i]),
         .d_i (anc_i[i]),
         .a_o (a_o[i]),
         .b_o (b_o[i]),
         .s_o (s_o[i]),
         .k_o (k_o[i])
      );
   end
endmodule

// File: rtl/rva_stage.sv
// Optional output register, chosen at elaboration.
module rva_stage #(
   parameter int DW      = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_comb
      assign q = d;
   end
endmodule

// File: rtl/rev_add_net.sv
module rev_add_net
   import rva_pkg::*;
#(
   parameter int WIDTH   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode,
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   input  logic [WIDTH-1:0] in_c,
   input  logic [WIDTH-1:0] in_anc,
   output logic [WIDTH-1:0] out_a,
   output logic [WIDTH-1:0] out_b,
   output logic [WIDTH-1:0] out_c,
   output logic [WIDTH-1:0] out_anc
);
   localparam int BUS = 4 * WIDTH;

   if (WIDTH < 2) begin : g_bad_width
      $error("rev_add_net: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] rp_a, rp_s, rp_k;
   logic             rp_cin;
   logic [WIDTH-1:0] cs_a, cs_b, cs_s, cs_k;
   logic [BUS-1:0]   net_bus, out_bus;

   rva_ripple #(.WIDTH(WIDTH)) u_ripple (
      .a_i   (in_a),
      .b_i   (in_b),
      .cin_i (in_c[0]),
      .anc_i (in_anc),
      .a_o   (rp_a),
      .sum_o (rp_s),
      .cin_o (rp_cin),
      .anc_o (rp_k)
   );

   rva_csa #(.WIDTH(WIDTH)) u_csa (
      .a_i   (in_a),
      .b_i   (in_b),
      .c_i   (in_c),
      .anc_i (in_anc),
      .a_o   (cs_a),
      .b_o   (cs_b),
      .s_o   (cs_s),
      .k_o   (cs_k)
   );

   always_comb begin
      if (rva_mode_e'(mode) == MODE_CSA)
         net_bus = {cs_a, cs_b, cs_s, cs_k};
      else
         net_bus = {rp_a, rp_s, in_c[WIDTH-1:1], rp_cin, rp_k};
   end

   rva_stage #(.DW(BUS), .REG_OUT(REG_OUT)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (net_bus),
      .q     (out_bus)
   );

   assign {out_a, out_b, out_c, out_anc} = out_bus;
endmodule

// File: rtl/rev_add_net_chk.sv
module rev_add_net_chk #(
   parameter int WIDTH   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode,
   input logic [WIDTH-1:0] in_a,
   input logic [WIDTH-1:0] in_b,
   input logic [WIDTH-1:0] in_c,
   input logic [WIDTH-1:0] in_anc,
   input logic [WIDTH-1:0] out_a,
   input logic [WIDTH-1:0] out_b,
   input logic [WIDTH-1:0] out_c,
   input logic [WIDTH-1:0] out_anc
);
   logic             d_v, d_mode;
   logic [WIDTH-1:0] d_a, d_b, d_c;

   if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) d_v <= 1'b0;
         else        d_v <= 1'b1;
      end
      always_ff @(posedge clk) begin
         d_mode <= mode;
         d_a    <= in_a;
         d_b    <= in_b;
         d_c    <= in_c;
      end
      // R9
      reset_clear_chk: assert property (@(posedge clk)
         !rst_n |=> (out_a == '0 && out_b == '0 && out_c == '0 && out_anc == '0));
   end else begin : g_now
      assign d_v    = 1'b1;
      assign d_mode = mode;
      assign d_a    = in_a;
      assign d_b    = in_b;
      assign d_c    = in_c;
   end

   // R8
   anc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_anc == '0);

   // R5
   anc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_v && !d_mode) |-> out_anc[WIDTH-2:0] == '0);

   // R4
   ripple_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_v && !d_mode) |->
      {out_anc[WIDTH-1], out_b} ==
      ({1'b0, d_a} + {1'b0, d_b} + {{WIDTH{1'b0}}, d_c[0]}));

   // R6
   ripple_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_v && !d_mode) |-> (out_a == d_a && out_c == d_c));

   // R7
   csa_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_v && d_mode) |->
      ({2'b0, out_c} + {1'b0, out_anc, 1'b0}) ==
      ({2'b0, d_a} + {2'b0, d_b} + {2'b0, d_c}));

   // R7
   csa_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_v && d_mode) |-> (out_a == d_a && out_b == d_b));
endmodule

bind rev_add_net rev_add_net_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode    (mode),
   .in_a    (in_a),
   .in_b    (in_b),
   .in_c    (in_c),
   .in_anc  (in_anc),
   .out_a   (out_a),
   .out_b   (out_b),
   .out_c   (out_c),
   .out_anc (out_anc)
);

// File: tb/rev_add_net_bench.sv
`timescale 1ns/1ps
module rev_add_net_bench;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mode = 1'b0;
   logic [W-1:0] in_a = '0, in_b = '0, in_c = '0, in_anc = '0;
   logic [W-1:0] out_a, out_b, out_c, out_anc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rev_add_net #(.WIDTH(W), .REG_OUT(1'b1)) u_rev_add_net (
      .clk (clk), .rst_n (rst_n), .mode (mode),
      .in_a (in_a), .in_b (in_b), .in_c (in_c), .in_anc (in_anc),
      .out_a (out_a), .out_b (out_b), .out_c (out_c), .out_anc (out_anc)
   );

   // Stand-alone cells for the truth-table sweeps.
   logic [3:0] cv = '0;
   logic fa_a, fa_b, fa_s, fa_k;
   logic mj_a, mj_b, mj_c, mj_k;

   rva_fa_cell u_fa_probe (
      .a_i (cv[0]), .b_i (cv[1]), .c_i (cv[2]), .d_i (cv[3]),
      .a_o (fa_a), .b_o (fa_b), .s_o (fa_s), .k_o (fa_k)
   );
   rva_maj_cell u_mj_probe (
      .a_i (cv[0]), .b_i (cv[1]), .c_i (cv[2]), .d_i (cv[3]),
      .a_o (mj_a), .b_o (mj_b), .c_o (mj_c), .k_o (mj_k)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] outs();
      return {out_a, out_b, out_c, out_anc};
   endfunction

   // Expected bus for one vector, from the arithmetic in the requirements.
   function automatic logic [15:0] expect_bus(input logic m, input int a,
                                              input int b, input int c);
      int tot;
      int s;
      int k;
      if (!m) begin
         tot = a + b + (c & 1);
         return {4'(a), 4'(tot % 16), 4'(c), 4'((tot / 16) * 8)};
      end
      s = 0;
      k = 0;
      for (int i = 0; i < W; i++) begin
         int n;
         n = ((a >> i) & 1) + ((b >> i) & 1) + ((c >> i) & 1);
         s = s | ((n % 2) << i);
         k = k | ((n / 2) << i);
      end
      return {4'(a), 4'(b), 4'(s), 4'(k)};
   endfunction

   initial begin : watchdog
      #(2_000_000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] seen_fa;
      logic [15:0] seen_mj;
      logic [15:0] exp;
      logic [15:0] prev;

      // R1 R2 R3: exhaustive cell tables and permutation check
      seen_fa = '0;
      seen_mj = '0;
      for (int v = 0; v < 16; v++) begin
         logic ea, eb, ec, ed, em;
         cv = 4'(v);
         #1;
         ea = cv[0]; eb = cv[1]; ec = cv[2]; ed = cv[3];
         em = ((32'(ea) + 32'(eb) + 32'(ec)) >= 2);
         check({fa_k, fa_s, fa_b, fa_a} == {ed ^ em, ea ^ eb ^ ec, eb, ea},
               "R1", "full-adder cell row", {fa_k, fa_s, fa_b, fa_a},
               {ed ^ em, ea ^ eb ^ ec, eb, ea});
         check({mj_k, mj_c, mj_b, mj_a} == {ed ^ em, ec, eb, ea},
               "R2", "majority cell row", {mj_k, mj_c, mj_b, mj_a},
               {ed ^ em, ec, eb, ea});
         seen_fa[{fa_k, fa_s, fa_b, fa_a}] = 1'b1;
         seen_mj[{mj_k, mj_c, mj_b, mj_a}] = 1'b1;
      end
      check(seen_fa == 16'hFFFF, "R3", "full-adder cell permutation", seen_fa, 16'hFFFF);
      check(seen_mj == 16'hFFFF, "R3", "majority cell permutation", seen_mj, 16'hFFFF);

      // R9: reset holds the outputs at zero even with live inputs
      @(negedge clk);
      in_a = 4'hF; in_b = 4'hF; in_c = 4'hF;
      @(negedge clk);
      check(outs() == '0, "R9", "outputs during reset", outs(), 16'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R4 R5 R6 R7: full sweep in both modes
      for (int m = 0; m < 2; m++) begin
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
               for (int c = 0; c < 16; c++) begin
                  mode = 1'(m);
                  in_a = 4'(a); in_b = 4'(b); in_c = 4'(c); in_anc = '0;
                  exp = expect_bus(1'(m), a, b, c);
                  @(negedge clk);
                  if (m == 0) begin
                     check(outs() == exp, "R4", "ripple sum/carry-out/pass", outs(), exp);
                     check(out_anc[W-2:0] == '0, "R5", "ripple ancilla cleared",
                           32'(out_anc), 32'(exp[3:0]));
                     check(out_a == 4'(a) && out_c == 4'(c), "R6", "ripple pass lines",
                           {out_a, out_c}, {4'(a), 4'(c)});
                  end else begin
                     check(outs() == exp, "R7", "carry-save bit cells", outs(), exp);
                     check(32'(out_c) + 2 * 32'(out_anc) == 32'(a + b + c), "R7",
                           "carry-save weighted total", 32'(out_c) + 2 * 32'(out_anc),
                           32'(a + b + c));
                  end
               end
            end
         end
      end

      // R9: new inputs do not reach the outputs before the next edge
      mode = 1'b0; in_a = 4'h3; in_b = 4'h5; in_c = 4'h0;
      @(negedge clk);
      prev = expect_bus(1'b0, 3, 5, 0);
      check(outs() == prev, "R9", "settled before latency probe", outs(), prev);
      in_a = 4'hF; in_b = 4'hF; in_c = 4'h1;
      #2;
      check(outs() == prev, "R9", "output held until clock edge", outs(), prev);
      @(negedge clk);
      exp = expect_bus(1'b0, 15, 15, 1);
      check(outs() == exp, "R9", "output one clock after input", outs(), exp);
      check(out_anc == 4'h8 && out_b == 4'hF, "R4", "all-ones with carry-in",
            {out_anc, out_b}, 8'h8F);

      // R8: ancillas remained zero on entry through the run; a final
      // carry-save vector confirms zero ancillas give zero-weight excess
      mode = 1'b1; in_a = 4'h0; in_b = 4'h0; in_c = 4'h0; in_anc = '0;
      @(negedge clk);
      check(outs() == '0, "R8", "zero lines with zero ancilla", outs(), 16'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule